// File: doc/BRIEF.md
# 24-bit Instruction Field Decoder

This block takes one 24-bit instruction word per cycle and turns it into the control and operand fields that a datapath needs. The major opcode occupies the top six bits. Its upper bits assign the word to one of four classes: arithmetic with an immediate operand, arithmetic with a register operand, memory transfer, or control flow. The block then pulls out the destination and source register indices for that class, together with an immediate that is sign-extended to the datapath width. It also produces the ALU operation, the memory read, write and doubleword strobes, and the branch, jump and link controls.

The result is registered, so a word presented with `in_valid` high appears decoded on the outputs after the next rising clock edge. Words whose opcode pattern is not assigned are reported on `out_illegal`, and every enable is withheld for them. Register index 0 is the constant-zero register. The decoder never requests a write to it, and every source index that a format does not use is reported as 0.

Top module: `insn_decode24`

## Requirements
- R1: When `in_valid` is high at a rising edge, the outputs show the decode of `in_instr` sampled at that edge, and `out_valid` is high, until the next edge.
- R2: While `rst_n` is low, every output is 0.
- R3: `out_cls` is 0 for opcode `0xxxx0`, 1 for `0xxxx1`, 2 for `10xxxx` and 3 for `11xxxx`. Memory strobes occur only in class 2, and branch or jump controls only in class 3.
- R4: For an arithmetic opcode `0XXXXr` with XXXX from 0 to 11, `out_alu_op` = XXXX and `out_use_imm` = not r. The immediate form takes the destination from bits [17:14], source A from [13:10] and the immediate from [9:0]. The register form takes source B from [9:6], and its immediate output is 0.
- R5: Opcode `000010` loads an upper immediate. It gives ALU op 0 (add), source A 0, and an immediate equal to bits [13:0] shifted left by XLEN-14.
- R6: For `10 0 d s x`: s=1 is a store (write strobe, no register write), s=0 is a load (read strobe, register write), d sets the doubleword flag, and x=1 selects the indexed form. Source A comes from bits [17:14] and the data register from [13:10]. The offset is bits [9:0], or B from [9:6] plus bits [5:0] when indexed. The ALU op is add with the immediate.
- R7: Opcode `110ccc` is a conditional branch. `out_br_cond` = ccc, source A = bits [17:14], source B = bits [13:10], the offset is [9:0] sign-extended, the ALU op is 1 (subtract) with no immediate operand, and no register is written. ccc = 110 or 111 is illegal.
- R8: Opcode `111000` jumps to A [17:14] plus the sign-extended bits [13:0]. Opcode `111110` jumps to A [17:14] + B [9:6] + the sign-extended bits [5:0], asserts link, and writes the return address to the register in bits [13:10].
- R9: `out_rd_we` is never high when `out_rd` is 0.
- R10: Any register index that the decoded format does not use is output as 0.
- R11: The following are illegal: arithmetic operation codes 12 to 15, the register form with nonzero bits [5:0], opcodes `101xxx`, branch conditions 110 and 111, and `111` opcodes other than `000` and `110`. For an illegal word, `out_illegal` is 1 and every other output apart from `out_valid` is 0.
- R12: When `in_valid` is low at an edge, every output, including `out_valid` and `out_illegal`, is 0 until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word present |
| in_instr | input | 24 | Instruction word |
| out_valid | output | 1 | Decoded word present |
| out_illegal | output | 1 | Unassigned opcode pattern |
| out_cls | output | 2 | Class: 0 ALU-imm, 1 ALU-reg, 2 memory, 3 control flow |
| out_rd | output | 4 | Destination or store-data register index |
| out_ra | output | 4 | Source A register index |
| out_rb | output | 4 | Source B register index |
| out_alu_op | output | 4 | ALU operation code |
| out_use_imm | output | 1 | Second ALU operand is the immediate |
| out_rd_we | output | 1 | Register write request |
| out_mem_rd | output | 1 | Memory read |
| out_mem_wr | output | 1 | Memory write |
| out_mem_dbl | output | 1 | Doubleword transfer |
| out_br_en | output | 1 | Conditional branch |
| out_br_cond | output | 3 | Branch condition code |
| out_jump | output | 1 | Unconditional jump |
| out_link | output | 1 | Jump writes return address |
| out_imm | output | XLEN | Sign-extended immediate |

## Verification
The properties assume that `in_valid` and `in_instr` carry known 0/1 values at every rising edge once reset is released, and that `rst_n` is low from time zero. The stimulus respects this. It changes inputs only on falling edges, drives fully specified words from a table of legal and illegal encodings, and holds reset low before the first clock edge. The properties also assume that an illegal word counts as valid, which is why it reports `out_valid` high. The bench feeds both kinds of word back to back and interleaves idle cycles.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

    localparam int INSN_W = 24;
    localparam int OPC_W  = 6;
    localparam int IDX_W  = 4;
    localparam int COND_W = 3;

    typedef enum logic [1:0] {
        CLS_ALU_IMM = 2'd0,
        CLS_ALU_REG = 2'd1,
        CLS_MEM     = 2'd2,
        CLS_FLOW    = 2'd3
    } cls_e;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_SLL  = 4'd2,
        OP_SRL  = 4'd3,
        OP_SRA  = 4'd4,
        OP_XOR  = 4'd5,
        OP_OR   = 4'd6,
        OP_AND  = 4'd7,
        OP_MUL  = 4'd8,
        OP_MULH = 4'd9,
        OP_DIVU = 4'd10,
        OP_REMU = 4'd11
    } aluop_e;

    localparam logic [3:0] LAST_ALU_OP = 4'd11;

    typedef struct packed {
        logic              illegal;
        cls_e              cls;
        logic [IDX_W-1:0]  rd;
        logic [IDX_W-1:0]  ra;
        logic [IDX_W-1:0]  rb;
        aluop_e            op;
        logic              use_imm;
        logic              rd_we;
        logic              mem_rd;
        logic              mem_wr;
        logic              mem_dbl;
        logic              br_en;
        logic [COND_W-1:0] cond;
        logic              jump;
        logic              link;
    } ctl_t;

endpackage

// File: rtl/insn_dec_alu.sv
module insn_dec_alu
    import insn_dec_pkg::*;
#(
    parameter int XLEN = 24
) (
    input  logic [INSN_W-1:0] instr,
    output ctl_t              ctl,
    output logic [XLEN-1:0]   imm
);
    localparam int OPC_LSB  = INSN_W - OPC_W;
    localparam int IMM_W    = 10;
    localparam int UPPER_W  = 14;

    logic [OPC_W-1:0] opc;
    logic [3:0]       fn;
    logic             reg_form;
    logic             alu_unused;

    assign opc        = instr[INSN_W-1:OPC_LSB];
    assign fn         = opc[4:1];
    assign reg_form   = opc[0];
    assign alu_unused = opc[5];

    always_comb begin
        ctl    = '0;
        imm    = '0;
        ctl.rd = instr[17:14];
        ctl.rd_we = 1'b1;
        if (fn > LAST_ALU_OP) begin
            ctl.illegal = 1'b1;
        end else if (reg_form) begin
            ctl.cls     = CLS_ALU_REG;
            ctl.ra      = instr[13:10];
            ctl.rb      = instr[9:6];
            ctl.op      = aluop_e'(fn);
            ctl.use_imm = 1'b0;
            if (instr[5:0] != 6'd0) begin
                ctl.illegal = 1'b1;
            end
        end else if (fn == 4'd1) begin
            ctl.cls     = CLS_ALU_IMM;
            ctl.ra      = '0;
            ctl.op      = OP_ADD;
            ctl.use_imm = 1'b1;
            imm         = {instr[UPPER_W-1:0], {(XLEN-UPPER_W){1'b0}}};
        end else begin
            ctl.cls     = CLS_ALU_IMM;
            ctl.ra      = instr[13:10];
            ctl.op      = aluop_e'(fn);
            ctl.use_imm = 1'b1;
            imm         = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
        end
    end

endmodule

// File: rtl/insn_dec_mem.sv
module insn_dec_mem
    import insn_dec_pkg::*;
#(
    parameter int XLEN = 24
) (
    input  logic [INSN_W-1:0] instr,
    output ctl_t              ctl,
    output logic [XLEN-1:0]   imm
);
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int OFS_W   = 10;
    localparam int IOFS_W  = 6;

    logic [OPC_W-1:0] opc;
    logic             indexed;
    logic             store;
    logic             dbl;
    logic [1:0]       mem_unused;

    assign opc        = instr[INSN_W-1:OPC_LSB];
    assign indexed    = opc[0];
    assign store      = opc[1];
    assign dbl        = opc[2];
    assign mem_unused = opc[5:4];

    always_comb begin
        ctl = '0;
        imm = '0;
        if (opc[3]) begin
            ctl.illegal = 1'b1;
        end else begin
            ctl.cls     = CLS_MEM;
            ctl.ra      = instr[17:14];
            ctl.rd      = instr[13:10];
            ctl.op      = OP_ADD;
            ctl.use_imm = 1'b1;
            ctl.rd_we   = ~store;
            ctl.mem_rd  = ~store;
            ctl.mem_wr  = store;
            ctl.mem_dbl = dbl;
            if (indexed) begin
                ctl.rb = instr[9:6];
                imm    = {{(XLEN-IOFS_W){instr[IOFS_W-1]}}, instr[IOFS_W-1:0]};
            end else begin
                imm    = {{(XLEN-OFS_W){instr[OFS_W-1]}}, instr[OFS_W-1:0]};
            end
        end
    end

endmodule

// File: rtl/insn_dec_flow.sv
module insn_dec_flow
    import insn_dec_pkg::*;
#(
    parameter int XLEN = 24
) (
    input  logic [INSN_W-1:0] instr,
    output ctl_t              ctl,
    output logic [XLEN-1:0]   imm
);
    localparam int OPC_LSB = INSN_W - OPC_W;
    localparam int BOFS_W  = 10;
    localparam int JOFS_W  = 14;
    localparam int LOFS_W  = 6;

    logic [OPC_W-1:0] opc;
    logic [1:0]       flow_unused;

    assign opc         = instr[INSN_W-1:OPC_LSB];
    assign flow_unused = opc[5:4];

    always_comb begin
        ctl = '0;
        imm = '0;
        if (!opc[3]) begin
            if (opc[2:1] == 2'b11) begin
                ctl.illegal = 1'b1;
            end else begin
                ctl.cls     = CLS_FLOW;
                ctl.ra      = instr[17:14];
                ctl.rb      = instr[13:10];
                ctl.op      = OP_SUB;
                ctl.use_imm = 1'b0;
                ctl.br_en   = 1'b1;
                ctl.cond    = opc[2:0];
                imm         = {{(XLEN-BOFS_W){instr[BOFS_W-1]}}, instr[BOFS_W-1:0]};
            end
        end else begin
            unique case (opc[2:0])
                3'b000: begin
                    ctl.cls     = CLS_FLOW;
                    ctl.ra      = instr[17:14];
                    ctl.op      = OP_ADD;
                    ctl.use_imm = 1'b1;
                    ctl.jump    = 1'b1;
                    imm         = {{(XLEN-JOFS_W){instr[JOFS_W-1]}}, instr[JOFS_W-1:0]};
                end
                3'b110: begin
                    ctl.cls     = CLS_FLOW;
                    ctl.ra      = instr[17:14];
                    ctl.rd      = instr[13:10];
                    ctl.rb      = instr[9:6];
                    ctl.op      = OP_ADD;
                    ctl.use_imm = 1'b1;
                    ctl.jump    = 1'b1;
                    ctl.link    = 1'b1;
                    ctl.rd_we   = 1'b1;
                    imm         = {{(XLEN-LOFS_W){instr[LOFS_W-1]}}, instr[LOFS_W-1:0]};
                end
                default: begin
                    ctl.illegal = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/insn_decode24.sv
module insn_decode24
    import insn_dec_pkg::*;
#(
    parameter int XLEN = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [INSN_W-1:0]    in_instr,
    output logic                 out_valid,
    output logic                 out_illegal,
    output logic [1:0]           out_cls,
    output logic [IDX_W-1:0]     out_rd,
    output logic [IDX_W-1:0]     out_ra,
    output logic [IDX_W-1:0]     out_rb,
    output logic [3:0]           out_alu_op,
    output logic                 out_use_imm,
    output logic                 out_rd_we,
    output logic                 out_mem_rd,
    output logic                 out_mem_wr,
    output logic                 out_mem_dbl,
    output logic                 out_br_en,
    output logic [COND_W-1:0]    out_br_cond,
    output logic                 out_jump,
    output logic                 out_link,
    output logic [XLEN-1:0]      out_imm
);
    localparam int CLS_MSB = INSN_W - 1;
    localparam int CLS_LSB = INSN_W - 2;

    typedef struct packed {
        logic            vld;
        ctl_t            ctl;
        logic [XLEN-1:0] imm;
    } stage_t;

    ctl_t            alu_ctl, mem_ctl, flw_ctl, pick_ctl;
    logic [XLEN-1:0] alu_imm, mem_imm, flw_imm, pick_imm;
    stage_t          st_d, st_q;

    insn_dec_alu #(.XLEN(XLEN)) u_alu (
        .instr (in_instr),
        .ctl   (alu_ctl),
        .imm   (alu_imm)
    );

    insn_dec_mem #(.XLEN(XLEN)) u_mem (
        .instr (in_instr),
        .ctl   (mem_ctl),
        .imm   (mem_imm)
    );

    insn_dec_flow #(.XLEN(XLEN)) u_flow (
        .instr (in_instr),
        .ctl   (flw_ctl),
        .imm   (flw_imm)
    );

    always_comb begin
        unique case (in_instr[CLS_MSB:CLS_LSB])
            2'b10: begin
                pick_ctl = mem_ctl;
                pick_imm = mem_imm;
            end
            2'b11: begin
                pick_ctl = flw_ctl;
                pick_imm = flw_imm;
            end
            default: begin
                pick_ctl = alu_ctl;
                pick_imm = alu_imm;
            end
        endcase
    end

    always_comb begin
        st_d = '0;
        if (in_valid) begin
            st_d.vld = 1'b1;
            if (pick_ctl.illegal) begin
                st_d.ctl.illegal = 1'b1;
            end else begin
                st_d.ctl       = pick_ctl;
                st_d.ctl.rd_we = pick_ctl.rd_we && (pick_ctl.rd != '0);
                st_d.imm       = pick_imm;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_illegal = st_q.ctl.illegal;
    assign out_cls     = st_q.ctl.cls;
    assign out_rd      = st_q.ctl.rd;
    assign out_ra      = st_q.ctl.ra;
    assign out_rb      = st_q.ctl.rb;
    assign out_alu_op  = st_q.ctl.op;
    assign out_use_imm = st_q.ctl.use_imm;
    assign out_rd_we   = st_q.ctl.rd_we;
    assign out_mem_rd  = st_q.ctl.mem_rd;
    assign out_mem_wr  = st_q.ctl.mem_wr;
    assign out_mem_dbl = st_q.ctl.mem_dbl;
    assign out_br_en   = st_q.ctl.br_en;
    assign out_br_cond = st_q.ctl.cond;
    assign out_jump    = st_q.ctl.jump;
    assign out_link    = st_q.ctl.link;
    assign out_imm     = st_q.imm;

endmodule

// File: rtl/insn_decode24_chk.sv
module insn_decode24_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       out_valid,
    input logic       out_illegal,
    input logic [1:0] out_cls,
    input logic [3:0] out_rd,
    input logic [3:0] out_rb,
    input logic       out_rd_we,
    input logic       out_mem_rd,
    input logic       out_mem_wr,
    input logic       out_mem_dbl,
    input logic       out_br_en,
    input logic       out_jump,
    input logic       out_link
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R12
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_illegal || out_rd_we || out_mem_rd || out_mem_wr ||
                         out_br_en || out_jump || out_link));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !(out_rd_we || out_mem_rd || out_mem_wr || out_mem_dbl ||
                          out_br_en || out_jump || out_link));

    // R9
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_rd_we |-> (out_rd != 4'd0));

    // R6
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_mem_rd, out_mem_wr, out_br_en, out_jump}) <= 1);

    // R6
    dbl_needs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mem_dbl |-> (out_mem_rd || out_mem_wr));

    // R3
    mem_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mem_rd || out_mem_wr) |-> (out_cls == 2'd2));

    // R3
    flow_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_br_en || out_jump) |-> (out_cls == 2'd3));

    // R8
    link_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_link |-> out_jump);

    // R10
    imm_form_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_illegal && out_cls == 2'd0) |-> (out_rb == 4'd0));

endmodule

bind insn_decode24 insn_decode24_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_cls     (out_cls),
    .out_rd      (out_rd),
    .out_rb      (out_rb),
    .out_rd_we   (out_rd_we),
    .out_mem_rd  (out_mem_rd),
    .out_mem_wr  (out_mem_wr),
    .out_mem_dbl (out_mem_dbl),
    .out_br_en   (out_br_en),
    .out_jump    (out_jump),
    .out_link    (out_link)
);

// File: tb/insn_decode24_bench.sv
module insn_decode24_bench;

    localparam int XLEN  = 24;
    localparam int NVEC  = 21;

    typedef struct packed {
        logic [23:0] instr;
        logic [29:0] ctl;
        logic [23:0] imm;
        logic [3:0]  req;
    } vec_t;

    // ctl = {illegal, cls, rd, ra, rb, alu_op, {use_imm, rd_we, mem_rd, mem_wr, mem_dbl, br_en}, cond, {jump, link}}
    localparam vec_t VECS [0:NVEC-1] = '{
        // R4 immediate add, negative offset
        '{ {6'b000000, 4'd3, 4'd5, 10'h3FE}, {1'b0, 2'd0, 4'd3, 4'd5, 4'd0, 4'd0, 6'b110000, 3'd0, 2'b00}, 24'hFFFFFE, 4'd4 },
        // R4 register add
        '{ {6'b000001, 4'd7, 4'd1, 4'd2, 6'd0}, {1'b0, 2'd1, 4'd7, 4'd1, 4'd2, 4'd0, 6'b010000, 3'd0, 2'b00}, 24'h000000, 4'd4 },
        // R4 register subtract
        '{ {6'b000011, 4'd4, 4'd4, 4'd9, 6'd0}, {1'b0, 2'd1, 4'd4, 4'd4, 4'd9, 4'd1, 6'b010000, 3'd0, 2'b00}, 24'h000000, 4'd4 },
        // R5 upper immediate
        '{ {6'b000010, 4'd6, 14'h2ABC}, {1'b0, 2'd0, 4'd6, 4'd0, 4'd0, 4'd0, 6'b110000, 3'd0, 2'b00}, 24'hAAF000, 4'd5 },
        // R4 shift right arithmetic, immediate
        '{ {6'b001000, 4'd2, 4'd8, 10'd5}, {1'b0, 2'd0, 4'd2, 4'd8, 4'd0, 4'd4, 6'b110000, 3'd0, 2'b00}, 24'h000005, 4'd4 },
        // R4 highest operation code, register form
        '{ {6'b010111, 4'd15, 4'd14, 4'd13, 6'd0}, {1'b0, 2'd1, 4'd15, 4'd14, 4'd13, 4'd11, 6'b010000, 3'd0, 2'b00}, 24'h000000, 4'd4 },
        // R11 register form with nonzero tail
        '{ {6'b000001, 4'd7, 4'd1, 4'd2, 6'd1}, {1'b1, 29'd0}, 24'h000000, 4'd11 },
        // R11 operation code 12
        '{ {6'b011000, 4'd1, 4'd2, 10'd0}, {1'b1, 29'd0}, 24'h000000, 4'd11 },
        // R9 write to index zero suppressed
        '{ {6'b000000, 4'd0, 4'd1, 10'd3}, {1'b0, 2'd0, 4'd0, 4'd1, 4'd0, 4'd0, 6'b100000, 3'd0, 2'b00}, 24'h000003, 4'd9 },
        // R6 word load, base plus offset
        '{ {6'b100000, 4'd2, 4'd5, 10'h3FF}, {1'b0, 2'd2, 4'd5, 4'd2, 4'd0, 4'd0, 6'b111000, 3'd0, 2'b00}, 24'hFFFFFF, 4'd6 },
        // R6 doubleword store, indexed
        '{ {6'b100111, 4'd3, 4'd6, 4'd4, 6'd7}, {1'b0, 2'd2, 4'd6, 4'd3, 4'd4, 4'd0, 6'b100110, 3'd0, 2'b00}, 24'h000007, 4'd6 },
        // R6 doubleword load, indexed, most negative offset
        '{ {6'b100101, 4'd1, 4'd8, 4'd2, 6'b100000}, {1'b0, 2'd2, 4'd8, 4'd1, 4'd2, 4'd0, 6'b111010, 3'd0, 2'b00}, 24'hFFFFE0, 4'd6 },
        // R11 unassigned data opcode
        '{ {6'b101000, 4'd1, 4'd2, 10'd0}, {1'b1, 29'd0}, 24'h000000, 4'd11 },
        // R7 unsigned less-than branch
        '{ {6'b110010, 4'd9, 4'd10, 10'h3FC}, {1'b0, 2'd3, 4'd0, 4'd9, 4'd10, 4'd1, 6'b000001, 3'b010, 2'b00}, 24'hFFFFFC, 4'd7 },
        // R7 condition 110 unassigned
        '{ {6'b110110, 4'd1, 4'd2, 10'd0}, {1'b1, 29'd0}, 24'h000000, 4'd7 },
        // R8 indirect jump, 14-bit negative offset
        '{ {6'b111000, 4'd7, 14'h3FF0}, {1'b0, 2'd3, 4'd0, 4'd7, 4'd0, 4'd0, 6'b100000, 3'd0, 2'b10}, 24'hFFFFF0, 4'd8 },
        // R8 jump and link
        '{ {6'b111110, 4'd5, 4'd1, 4'd6, 6'd2}, {1'b0, 2'd3, 4'd1, 4'd5, 4'd6, 4'd0, 6'b110000, 3'd0, 2'b11}, 24'h000002, 4'd8 },
        // R9 jump and link to index zero
        '{ {6'b111110, 4'd5, 4'd0, 4'd6, 6'd2}, {1'b0, 2'd3, 4'd0, 4'd5, 4'd6, 4'd0, 6'b100000, 3'd0, 2'b11}, 24'h000002, 4'd9 },
        // R11 unassigned flow opcode
        '{ {6'b111111, 4'd1, 4'd2, 10'd0}, {1'b1, 29'd0}, 24'h000000, 4'd11 },
        // R7 signed greater-or-equal branch
        '{ {6'b110101, 4'd3, 4'd0, 10'd8}, {1'b0, 2'd3, 4'd0, 4'd3, 4'd0, 4'd1, 6'b000001, 3'b101, 2'b00}, 24'h000008, 4'd7 },
        // R6 word store, data register zero
        '{ {6'b100010, 4'd9, 4'd0, 10'd4}, {1'b0, 2'd2, 4'd0, 4'd9, 4'd0, 4'd0, 6'b100100, 3'd0, 2'b00}, 24'h000004, 4'd6 }
    };

    logic            clk;
    logic            rst_n;
    logic            in_valid;
    logic [23:0]     in_instr;
    logic            out_valid;
    logic            out_illegal;
    logic [1:0]      out_cls;
    logic [3:0]      out_rd;
    logic [3:0]      out_ra;
    logic [3:0]      out_rb;
    logic [3:0]      out_alu_op;
    logic            out_use_imm;
    logic            out_rd_we;
    logic            out_mem_rd;
    logic            out_mem_wr;
    logic            out_mem_dbl;
    logic            out_br_en;
    logic [2:0]      out_br_cond;
    logic            out_jump;
    logic            out_link;
    logic [XLEN-1:0] out_imm;

    int n_checks = 0;
    int n_fail   = 0;
    logic [29:0] act_ctl;

    insn_decode24 #(.XLEN(XLEN)) u_insn_decode24 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_cls     (out_cls),
        .out_rd      (out_rd),
        .out_ra      (out_ra),
        .out_rb      (out_rb),
        .out_alu_op  (out_alu_op),
        .out_use_imm (out_use_imm),
        .out_rd_we   (out_rd_we),
        .out_mem_rd  (out_mem_rd),
        .out_mem_wr  (out_mem_wr),
        .out_mem_dbl (out_mem_dbl),
        .out_br_en   (out_br_en),
        .out_br_cond (out_br_cond),
        .out_jump    (out_jump),
        .out_link    (out_link),
        .out_imm     (out_imm)
    );

    assign act_ctl = {out_illegal, out_cls, out_rd, out_ra, out_rb, out_alu_op,
                      out_use_imm, out_rd_we, out_mem_rd, out_mem_wr, out_mem_dbl, out_br_en,
                      out_br_cond, out_jump, out_link};

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_instr = {6'b000001, 4'd7, 4'd1, 4'd2, 6'd0};
        repeat (3) @(negedge clk);
        // R2 reset holds every output at zero even with a valid word present
        check("R2 ctl", 64'(act_ctl), 64'd0);
        check("R2 imm", 64'(out_imm), 64'd0);
        check("R2 valid", 64'(out_valid), 64'd0);
        rst_n = 1'b1;

        // R1 table walk, one word per cycle, sampled one edge later
        for (int i = 0; i < NVEC; i++) begin
            in_valid = 1'b1;
            in_instr = VECS[i].instr;
            @(negedge clk);
            check($sformatf("R%0d vec%0d ctl", VECS[i].req, i), 64'(act_ctl), 64'(VECS[i].ctl));
            check($sformatf("R%0d vec%0d imm", VECS[i].req, i), 64'(out_imm), 64'(VECS[i].imm));
            check($sformatf("R1 vec%0d valid", i), 64'(out_valid), 64'd1);
        end

        // R12 idle cycle with a legal load word on the bus
        in_valid = 1'b0;
        in_instr = {6'b100000, 4'd2, 4'd5, 10'h3FF};
        @(negedge clk);
        check("R12 idle ctl", 64'(act_ctl), 64'd0);
        check("R12 idle imm", 64'(out_imm), 64'd0);
        check("R12 idle valid", 64'(out_valid), 64'd0);

        // R12 idle cycle with an illegal word: no illegal report
        in_instr = {6'b111111, 18'd0};
        @(negedge clk);
        check("R12 idle illegal", 64'(out_illegal), 64'd0);

        // R1 output holds the latest word only; back to back after idle
        in_valid = 1'b1;
        in_instr = {6'b111110, 4'd5, 4'd1, 4'd6, 6'd2};
        @(negedge clk);
        check("R8 link after idle", 64'({out_valid, out_link, out_rd_we, out_rd}), 64'({1'b1, 1'b1, 1'b1, 4'd1}));

        // R11 illegal word still reports valid
        in_instr = {6'b011110, 18'h3FFFF};
        @(negedge clk);
        check("R11 illegal valid", 64'({out_valid, out_illegal}), 64'({1'b1, 1'b1}));
        check("R11 illegal imm", 64'(out_imm), 64'd0);

        // R2 asynchronous reset mid-stream clears at once
        in_instr = {6'b000000, 4'd3, 4'd5, 10'h3FE};
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        check("R2 async ctl", 64'(act_ctl), 64'd0);
        check("R2 async imm", 64'(out_imm), 64'd0);
        check("R2 async valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 source B reported zero for immediate form after reset release
        check("R10 rb zero", 64'({out_valid, out_rb, out_ra}), 64'({1'b1, 4'd0, 4'd5}));

        finish_run();
    end

endmodule